// File: doc/BRIEF.md
# Fast Context Shadow Register

This block keeps a single saved copy of three core registers (the 5-bit status word, the 8-bit working register and the 4-bit bank selector) so that an interrupt handler or a short subroutine can return without saving and restoring them in software. Whenever the core vectors to any interrupt, or executes a call flagged as fast, the live values of the three registers are copied into the shadow. When the core executes a return flagged as fast, the shadow contents are presented on the restore outputs together with a one-cycle valid pulse, and the core writes them back into its working registers.

The shadow is one entry deep and has no software access. Every capture overwrites it without condition, so a higher-priority interrupt taken inside a lower-priority handler destroys the context saved on the first entry. A return without the fast flag neither touches the shadow nor raises restore-valid.

The restore side is a two-state machine. `RP_IDLE` is the reset state; a fast return moves it to `RP_PULSE` (transition *restore-start*). In `RP_PULSE` another fast return keeps it there (*restore-again*), anything else takes it back to `RP_IDLE` (*restore-end*). The restore-valid output is high exactly while the machine is in `RP_PULSE`.

Top module: `fast_ctx_shadow`

## Requirements
- R1: After reset the shadow and the restore outputs are all zero and restore-valid is low; a fast return with no prior capture delivers zeros.
- R2: An interrupt vectoring strobe copies the live status, working and bank values into the shadow at that clock edge.
- R3: A call strobe with the fast flag set captures the live values; a call strobe with the fast flag clear leaves the shadow unchanged.
- R4: A return strobe with the fast flag set raises restore-valid in the following cycle only, with the restore data equal to the shadow contents held at the strobe edge; the restore data holds its value between restores.
- R5: A return strobe with the fast flag clear leaves the shadow unchanged and keeps restore-valid low.
- R6: A second capture before any restore replaces the first saved context completely; only the latest one can be restored.
- R7: When a capture and a fast return occur in the same cycle, the restore delivers the contents from before that cycle and the shadow takes the new live values.
- R8: A fast return does not alter the shadow; repeated fast returns deliver the same context.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| live_status | input | 5 | Current status register value |
| live_wreg | input | 8 | Current working register value |
| live_bsr | input | 4 | Current bank-select value |
| irq_vector | input | 1 | Core is vectoring to an interrupt this cycle |
| call_req | input | 1 | Core executes a call this cycle |
| call_fast | input | 1 | The call is flagged fast |
| ret_req | input | 1 | Core executes a return this cycle |
| ret_fast | input | 1 | The return is flagged fast |
| restore_valid | output | 1 | Restore data is to be written back this cycle |
| restore_status | output | 5 | Saved status value |
| restore_wreg | output | 8 | Saved working register value |
| restore_bsr | output | 4 | Saved bank-select value |

## Verification
The vector table drives capture by interrupt and by fast call, each followed by a fast return with different live values on the inputs, which tells a true saved copy apart from a path that merely forwards the live registers. Plain calls and plain returns carrying distinct data separate the fast flag from the bare strobe. Two back-to-back interrupts followed by a return distinguish a one-deep overwrite from any stacking, and a capture coinciding with a restore shows whether the restore reads the old contents. A mid-run reset and a restore straight after it confirm the cleared state.

// File: rtl/ctx_shadow_pkg.sv
package ctx_shadow_pkg;
    localparam int STATUS_W = 5;
    localparam int WREG_W   = 8;
    localparam int BSR_W    = 4;
    localparam int CTX_W    = STATUS_W + WREG_W + BSR_W;

    typedef enum logic {
        RP_IDLE  = 1'b0,
        RP_PULSE = 1'b1
    } rp_state_e;
endpackage

// File: rtl/ctx_shadow_bank.sv
module ctx_shadow_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= d;
        end
    end

    // R8: contents change only on a load
    assert_bank_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(q));
endmodule

// File: rtl/ctx_restore_fsm.sv
module ctx_restore_fsm
    import ctx_shadow_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_vector,
    input  logic call_req,
    input  logic call_fast,
    input  logic ret_req,
    input  logic ret_fast,
    output logic capture_en,
    output logic restore_en,
    output logic restore_valid
);
    rp_state_e state_q, state_d;

    // decode of the core's strobes
    always_comb begin
        capture_en = irq_vector | (call_req & call_fast);
        restore_en = ret_req & ret_fast;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RP_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RP_IDLE:  state_d = restore_en ? RP_PULSE : RP_IDLE;   // restore-start
            RP_PULSE: state_d = restore_en ? RP_PULSE : RP_IDLE;   // restore-again / restore-end
            default:  state_d = RP_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        restore_valid = 1'b0;
        unique case (state_q)
            RP_IDLE:  restore_valid = 1'b0;
            RP_PULSE: restore_valid = 1'b1;
            default:  restore_valid = 1'b0;
        endcase
    end

    // R4: a fast return yields a valid pulse in the next cycle
    assert_valid_after_fast_ret_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && ret_fast) |=> restore_valid);
    // R5: without a fast return there is no pulse next cycle
    assert_no_valid_plain_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_req && ret_fast) |=> !restore_valid);
endmodule

// File: rtl/fast_ctx_shadow.sv
module fast_ctx_shadow
    import ctx_shadow_pkg::*;
#(
    parameter int ST_W = STATUS_W,
    parameter int WR_W = WREG_W,
    parameter int BS_W = BSR_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ST_W-1:0] live_status,
    input  logic [WR_W-1:0] live_wreg,
    input  logic [BS_W-1:0] live_bsr,
    input  logic            irq_vector,
    input  logic            call_req,
    input  logic            call_fast,
    input  logic            ret_req,
    input  logic            ret_fast,
    output logic            restore_valid,
    output logic [ST_W-1:0] restore_status,
    output logic [WR_W-1:0] restore_wreg,
    output logic [BS_W-1:0] restore_bsr
);
    localparam int CW = ST_W + WR_W + BS_W;

    logic          capture_en;
    logic          restore_en;
    logic [CW-1:0] live_ctx;
    logic [CW-1:0] shadow_ctx;
    logic [CW-1:0] out_ctx;

    assign live_ctx = {live_status, live_wreg, live_bsr};

    ctx_restore_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .irq_vector    (irq_vector),
        .call_req      (call_req),
        .call_fast     (call_fast),
        .ret_req       (ret_req),
        .ret_fast      (ret_fast),
        .capture_en    (capture_en),
        .restore_en    (restore_en),
        .restore_valid (restore_valid)
    );

    // the one-deep shadow: every capture overwrites it
    ctx_shadow_bank #(.W(CW)) u_shadow (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (capture_en),
        .d     (live_ctx),
        .q     (shadow_ctx)
    );

    // restore data register samples the pre-edge shadow contents
    ctx_shadow_bank #(.W(CW)) u_restore (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (restore_en),
        .d     (shadow_ctx),
        .q     (out_ctx)
    );

    assign restore_status = out_ctx[CW-1 -: ST_W];
    assign restore_wreg   = out_ctx[BS_W +: WR_W];
    assign restore_bsr    = out_ctx[BS_W-1:0];

    // R2: an interrupt entry stores the live registers
    assert_irq_captures_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_vector |=> (shadow_ctx == $past({live_status, live_wreg, live_bsr})));
    // R3: a plain call with no interrupt keeps the shadow
    assert_plain_call_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (call_req && !call_fast && !irq_vector) |=> $stable(shadow_ctx));
    // R7: restore data reflects the shadow before any same-cycle capture
    assert_restore_old_ctx_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_req && ret_fast) |=> ({restore_status, restore_wreg, restore_bsr} == $past(shadow_ctx)));
    // R4: restore data holds while no restore is pending
    assert_restore_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(ret_req && ret_fast) |=> $stable({restore_status, restore_wreg, restore_bsr}));
endmodule

// File: tb/fast_ctx_shadow_tb.sv
module fast_ctx_shadow_tb;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [4:0] live_status;
    logic [7:0] live_wreg;
    logic [3:0] live_bsr;
    logic       irq_vector, call_req, call_fast, ret_req, ret_fast;
    logic       restore_valid;
    logic [4:0] restore_status;
    logic [7:0] restore_wreg;
    logic [3:0] restore_bsr;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    fast_ctx_shadow u_dut (
        .clk(clk), .rst_n(rst_n),
        .live_status(live_status), .live_wreg(live_wreg), .live_bsr(live_bsr),
        .irq_vector(irq_vector), .call_req(call_req), .call_fast(call_fast),
        .ret_req(ret_req), .ret_fast(ret_fast),
        .restore_valid(restore_valid), .restore_status(restore_status),
        .restore_wreg(restore_wreg), .restore_bsr(restore_bsr)
    );

    // control {irq, call, call_fast, ret, ret_fast}, live st/w/b, expected valid/st/w/b
    localparam int NV = 14;
    localparam logic [39:0] VEC [NV] = '{
        {5'b00011, 5'h00, 8'h00, 4'h0, 1'b1, 5'h00, 8'h00, 4'h0},
        {5'b10000, 5'h0F, 8'hA5, 4'h3, 1'b0, 5'h00, 8'h00, 4'h0},
        {5'b00011, 5'h01, 8'h11, 4'h1, 1'b1, 5'h0F, 8'hA5, 4'h3},
        {5'b00010, 5'h1E, 8'hEE, 4'hE, 1'b0, 5'h0F, 8'hA5, 4'h3},
        {5'b00011, 5'h02, 8'h22, 4'h2, 1'b1, 5'h0F, 8'hA5, 4'h3},
        {5'b01100, 5'h0A, 8'h3C, 4'h9, 1'b0, 5'h0F, 8'hA5, 4'h3},
        {5'b01000, 5'h1F, 8'hFF, 4'hF, 1'b0, 5'h0F, 8'hA5, 4'h3},
        {5'b00011, 5'h05, 8'h55, 4'h5, 1'b1, 5'h0A, 8'h3C, 4'h9},
        {5'b10000, 5'h02, 8'h20, 4'h2, 1'b0, 5'h0A, 8'h3C, 4'h9},
        {5'b10000, 5'h04, 8'h40, 4'h4, 1'b0, 5'h0A, 8'h3C, 4'h9},
        {5'b00011, 5'h08, 8'h80, 4'h8, 1'b1, 5'h04, 8'h40, 4'h4},
        {5'b10011, 5'h11, 8'h77, 4'h7, 1'b1, 5'h04, 8'h40, 4'h4},
        {5'b00011, 5'h00, 8'h00, 4'h0, 1'b1, 5'h11, 8'h77, 4'h7},
        {5'b00000, 5'h13, 8'h99, 4'hC, 1'b0, 5'h11, 8'h77, 4'h7}
    };

    function automatic string vec_tag(input int i);
        case (i)
            0:  return "R1";
            1:  return "R2";
            2:  return "R2";
            3:  return "R5";
            4:  return "R8";
            5:  return "R3";
            6:  return "R3";
            7:  return "R3";
            8:  return "R6";
            9:  return "R6";
            10: return "R6";
            11: return "R7";
            12: return "R7";
            default: return "R4";
        endcase
    endfunction

    task automatic check_out(input string tag, input logic ev, input logic [4:0] es,
                             input logic [7:0] ew, input logic [3:0] eb);
        checks++;
        if (restore_valid !== ev || restore_status !== es || restore_wreg !== ew || restore_bsr !== eb) begin
            errors++;
            $display("FAIL %s: got v=%b s=%h w=%h b=%h, expected v=%b s=%h w=%h b=%h",
                     tag, restore_valid, restore_status, restore_wreg, restore_bsr, ev, es, ew, eb);
        end
    endtask

    task automatic drive(input logic [4:0] c, input logic [4:0] s, input logic [7:0] w, input logic [3:0] b);
        {irq_vector, call_req, call_fast, ret_req, ret_fast} = c;
        live_status = s; live_wreg = w; live_bsr = b;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                errors++;
                $display("FAIL watchdog: got %0d cycles, expected at most 5000", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        drive(5'b0, 5'h0, 8'h0, 4'h0);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check_out("R1 reset", 1'b0, 5'h00, 8'h00, 4'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: drive at negedge, sample at the next negedge
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][39:35], VEC[i][34:30], VEC[i][29:22], VEC[i][21:18]);
            @(negedge clk);
            check_out(vec_tag(i), VEC[i][17], VEC[i][16:12], VEC[i][11:4], VEC[i][3:0]);
        end

        // R4: back-to-back fast returns keep valid high both cycles
        drive(5'b00011, 5'h00, 8'h00, 4'h0);
        @(negedge clk);
        check_out("R4 first", 1'b1, 5'h11, 8'h77, 4'h7);
        @(negedge clk);
        check_out("R4 second", 1'b1, 5'h11, 8'h77, 4'h7);
        drive(5'b00000, 5'h00, 8'h00, 4'h0);
        @(negedge clk);
        check_out("R4 end", 1'b0, 5'h11, 8'h77, 4'h7);

        // R1: reset mid-run clears shadow and outputs
        rst_n = 1'b0;
        @(negedge clk);
        check_out("R1 mid reset", 1'b0, 5'h00, 8'h00, 4'h0);
        rst_n = 1'b1;
        drive(5'b00011, 5'h1B, 8'h5A, 4'hD);
        @(negedge clk);
        check_out("R1 restore after reset", 1'b1, 5'h00, 8'h00, 4'h0);
        drive(5'b00000, 5'h00, 8'h00, 4'h0);
        @(negedge clk);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule